// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the register block of an asynchronous serial port. It holds a status byte, two control bytes, a 16-bit baud divisor written as two bytes, and a data port. Two sides use it. A simple register bus (address, write strobe, read strobe, byte data) serves software. The receiver and transmitter engines use it as well. They get decoded line settings and a load strobe with each character to send. In return they report finished receptions and finished transmissions.

Three event flags record the port's progress, and each flag is cleared in its own way. The received-character flag clears when the data port is read. The transmit-finished flag clears when software writes a one to its bit, or when the data port is written. The data-empty flag is set again when the transmitter is switched on, or when a transmission finishes. Each flag drives an interrupt request through its own enable bit. A one-cycle pulse tells the serial engines that a setting affecting the line format or bit timing has been rewritten.

Top module: `sport_regfile`

## Requirements
- R1: After reset, the status byte reads 0x20, control byte B reads 0x00, control byte C reads 0x06, all three interrupt requests are low and the character length output is 8.
- R2: Status bit layout, MSB first: rx-done, tx-done, data-empty, frame error, overrun, parity error, double speed, multiprocessor mode. A status write stores only bits 1 and 0. A one written to bit 6 clears tx-done. All other written bits have no effect.
- R3: A control B write that turns bit 3 (transmit enable) from 0 to 1 sets data-empty. A write that leaves bit 3 set does not set it.
- R4: Writing the data port clears tx-done and data-empty. One cycle later it pulses tx_load, with tx_word = {control B bit 0, written byte}.
- R5: A tx_done pulse sets both tx-done and data-empty.
- R6: A rx_done pulse is taken only while control B bit 4 (receive enable) is set. When taken, it sets rx-done, stores rx_word, copies rx_ferr and rx_perr into status bits 4 and 2, and sets overrun (bit 3) if rx-done was already set. When receive enable is low, rx_done is ignored.
- R7: Reading the data port clears rx-done and returns the stored word masked to the character length. Control B bit 1 reads the stored bit 8.
- R8: The character length is decoded from {control B bit 2, control C bits 2:1}: codes 0 to 3 give 5 to 8, and codes 4 to 7 give 9. Control C bit 5 enables parity, bit 4 selects odd parity, and bit 3 selects two stop bits. Status bit 1 is double speed and status bit 0 is multiprocessor mode.
- R9: Each interrupt request is its flag ANDed with its enable (control B bit 7 rx-done, bit 6 tx-done, bit 5 data-empty), registered one clock after the flag and enable.
- R10: The rx-done request stays high for as long as the flag and its enable are set. Nothing clears it except clearing the flag or the enable.
- R11: cfg_changed pulses for one cycle, one clock after a write to control C or to either divisor byte. It also pulses after a write that changes double speed, or changes control B bits 4, 3 or 2. Any other write does not pulse it.
- R12: cfg_divisor is {divisor high byte, divisor low byte}. Offsets: status 0, control B 1, control C 2, divisor low 3, divisor high 4, data 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rx_done | input | 1 | Receiver finished a character |
| rx_word | input | 9 | Received character |
| rx_ferr | input | 1 | Frame error of that character |
| rx_perr | input | 1 | Parity error of that character |
| tx_done | input | 1 | Transmitter finished a character |
| tx_load | output | 1 | Character to send is ready |
| tx_word | output | 9 | Character to send |
| cfg_bits | output | 4 | Character length, 5 to 9 |
| cfg_parity_en | output | 1 | Parity enabled |
| cfg_parity_odd | output | 1 | Odd parity |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_dbl_speed | output | 1 | Double speed |
| cfg_mpcm | output | 1 | Multiprocessor mode |
| cfg_rx_en | output | 1 | Receiver enable |
| cfg_tx_en | output | 1 | Transmitter enable |
| cfg_divisor | output | DIV_W | Baud divisor |
| cfg_changed | output | 1 | Setting-change pulse |
| irq_rx_done | output | 1 | Receive interrupt request |
| irq_data_empty | output | 1 | Data-empty interrupt request |
| irq_tx_done | output | 1 | Transmit interrupt request |

## Verification
A flag with a wrong value shows up on two paths. The next status read returns it, and the matching interrupt request shows it one clock later. Because the requests are registered, every interrupt check samples one cycle after the flag check. A wrong change-detect result shows as a missing or extra cfg_changed pulse in the cycle right after the write. A wrong decode shows on the cfg outputs at once, and on the masked data read.

// File: rtl/sport_pkg.sv
package sport_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 9;
   localparam int N_IRQ  = 3;

   // status bit positions
   localparam int ST_RXC  = 7;
   localparam int ST_TXC  = 6;
   localparam int ST_DRE  = 5;
   localparam int ST_FE   = 4;
   localparam int ST_DOR  = 3;
   localparam int ST_UPE  = 2;
   localparam int ST_DBL  = 1;
   localparam int ST_MPCM = 0;

   // control B bit positions
   localparam int CB_RXIE = 7;
   localparam int CB_TXIE = 6;
   localparam int CB_DEIE = 5;
   localparam int CB_RXEN = 4;
   localparam int CB_TXEN = 3;
   localparam int CB_SZ2  = 2;
   localparam int CB_RB8  = 1;
   localparam int CB_TB8  = 0;

   localparam logic [BYTE_W-1:0] CTLC_RESET = 8'h06;

   typedef struct packed {
      logic rx_done;
      logic tx_done;
      logic data_empty;
   } flag_set_t;

   function automatic logic [3:0] decode_bits(input logic [2:0] code);
      return (code <= 3'd3) ? (4'd5 + {2'b00, code[1:0]}) : 4'd9;
   endfunction

   function automatic logic [BYTE_W-1:0] read_mask(input logic [3:0] bits);
      case (bits)
         4'd5:    return 8'h1F;
         4'd6:    return 8'h3F;
         4'd7:    return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
   import sport_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_status,
   input  logic              wr_ctlb,
   input  logic              wr_ctlc,
   input  logic              wr_divl,
   input  logic              wr_divh,
   input  logic [BYTE_W-1:0] wdata,
   output logic [7:2]        ctlb,
   output logic              txb8,
   output logic [BYTE_W-1:0] ctlc,
   output logic [DIV_W-1:0]  divisor,
   output logic              dbl,
   output logic              mpcm,
   output logic              tx_en_rise,
   output logic              changed
);
   localparam int HI_W = DIV_W - BYTE_W;

   logic fmt_hit;

   assign tx_en_rise = wr_ctlb && wdata[CB_TXEN] && !ctlb[CB_TXEN];

   always_comb begin
      fmt_hit = wr_ctlc || wr_divl || wr_divh;
      if (wr_status && (wdata[ST_DBL] != dbl))
         fmt_hit = 1'b1;
      if (wr_ctlb && (wdata[CB_RXEN:CB_SZ2] != ctlb[CB_RXEN:CB_SZ2]))
         fmt_hit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctlb    <= '0;
         txb8    <= 1'b0;
         ctlc    <= CTLC_RESET;
         divisor <= '0;
         dbl     <= 1'b0;
         mpcm    <= 1'b0;
         changed <= 1'b0;
      end else begin
         changed <= fmt_hit;
         if (wr_status) begin
            dbl  <= wdata[ST_DBL];
            mpcm <= wdata[ST_MPCM];
         end
         if (wr_ctlb) begin
            ctlb <= wdata[7:2];
            txb8 <= wdata[CB_TB8];
         end
         if (wr_ctlc) ctlc <= wdata;
         if (wr_divl) divisor[BYTE_W-1:0] <= wdata;
         if (wr_divh) divisor[DIV_W-1:BYTE_W] <= wdata[HI_W-1:0];
      end
   end
endmodule

// File: rtl/sport_flags.sv
module sport_flags
   import sport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic              st_wr,
   input  logic              st_w1c_tx,
   input  logic              tx_en_rise,
   input  logic              rx_accept,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_ferr,
   input  logic              rx_perr,
   input  logic              tx_done,
   output flag_set_t         flags,
   output logic              ferr,
   output logic              overrun,
   output logic              perr,
   output logic [WORD_W-1:0] rx_buf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '{rx_done: 1'b0, tx_done: 1'b0, data_empty: 1'b1};
         ferr    <= 1'b0;
         overrun <= 1'b0;
         perr    <= 1'b0;
         rx_buf  <= '0;
      end else begin
         // receive side: a new character wins over a read in the same cycle
         if (rx_accept) begin
            flags.rx_done <= 1'b1;
            rx_buf        <= rx_word;
            ferr          <= rx_ferr;
            perr          <= rx_perr;
            overrun       <= flags.rx_done;
         end else if (data_rd) begin
            flags.rx_done <= 1'b0;
         end
         // transmit side: a data write wins over engine events
         if (data_wr)
            flags.tx_done <= 1'b0;
         else if (tx_done)
            flags.tx_done <= 1'b1;
         else if (st_wr && st_w1c_tx)
            flags.tx_done <= 1'b0;
         if (data_wr)
            flags.data_empty <= 1'b0;
         else if (tx_done || tx_en_rise)
            flags.data_empty <= 1'b1;
      end
   end
endmodule

// File: rtl/sport_irq.sv
module sport_irq #(
   parameter int N   = 3,
   parameter bit REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flag,
   input  logic [N-1:0] enable,
   output logic [N-1:0] req
);
   for (genvar i = 0; i < N; i++) begin : g_line
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req[i] <= 1'b0;
            else        req[i] <= flag[i] & enable[i];
         end
      end else begin : g_comb
         assign req[i] = flag[i] & enable[i];
      end
   end
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile
   import sport_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DIV_W      = 16,
   parameter int OFF_STATUS = 0,
   parameter int OFF_CTLB   = 1,
   parameter int OFF_CTLC   = 2,
   parameter int OFF_DIVL   = 3,
   parameter int OFF_DIVH   = 4,
   parameter int OFF_DATA   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_done,
   input  logic [8:0]        rx_word,
   input  logic              rx_ferr,
   input  logic              rx_perr,
   input  logic              tx_done,
   output logic              tx_load,
   output logic [8:0]        tx_word,
   output logic [3:0]        cfg_bits,
   output logic              cfg_parity_en,
   output logic              cfg_parity_odd,
   output logic              cfg_two_stop,
   output logic              cfg_dbl_speed,
   output logic              cfg_mpcm,
   output logic              cfg_rx_en,
   output logic              cfg_tx_en,
   output logic [DIV_W-1:0]  cfg_divisor,
   output logic              cfg_changed,
   output logic              irq_rx_done,
   output logic              irq_data_empty,
   output logic              irq_tx_done
);
   localparam int N_REGS = 6;
   localparam int SPAN   = 1 << ADDR_W;

   if (DIV_W <= BYTE_W || DIV_W > 2 * BYTE_W) begin : g_bad_div
      $error("DIV_W must lie in 9..16");
   end
   if (SPAN < N_REGS) begin : g_bad_addr
      $error("ADDR_W too small for the register set");
   end
   if (OFF_STATUS == OFF_CTLB || OFF_STATUS == OFF_CTLC || OFF_STATUS == OFF_DIVL ||
       OFF_STATUS == OFF_DIVH || OFF_STATUS == OFF_DATA || OFF_CTLB == OFF_CTLC ||
       OFF_CTLB == OFF_DIVL || OFF_CTLB == OFF_DIVH || OFF_CTLB == OFF_DATA ||
       OFF_CTLC == OFF_DIVL || OFF_CTLC == OFF_DIVH || OFF_CTLC == OFF_DATA ||
       OFF_DIVL == OFF_DIVH || OFF_DIVL == OFF_DATA || OFF_DIVH == OFF_DATA) begin : g_bad_map
      $error("register offsets must be distinct");
   end

   // decoded strobes
   logic sel_status, sel_ctlb, sel_ctlc, sel_divl, sel_divh, sel_data;
   assign sel_status = (32'(bus_addr) == OFF_STATUS);
   assign sel_ctlb   = (32'(bus_addr) == OFF_CTLB);
   assign sel_ctlc   = (32'(bus_addr) == OFF_CTLC);
   assign sel_divl   = (32'(bus_addr) == OFF_DIVL);
   assign sel_divh   = (32'(bus_addr) == OFF_DIVH);
   assign sel_data   = (32'(bus_addr) == OFF_DATA);

   logic [7:2]        ctlb;
   logic              txb8;
   logic [BYTE_W-1:0] ctlc;
   logic              tx_en_rise;
   flag_set_t         flags;
   logic              st_rxc, st_tc, st_dre;
   logic              st_fe, st_dor, st_upe;
   logic [WORD_W-1:0] rx_buf;
   logic              ie_rx, ie_tx, ie_de;

   sport_ctrl #(.DIV_W(DIV_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_status  (bus_wr && sel_status),
      .wr_ctlb    (bus_wr && sel_ctlb),
      .wr_ctlc    (bus_wr && sel_ctlc),
      .wr_divl    (bus_wr && sel_divl),
      .wr_divh    (bus_wr && sel_divh),
      .wdata      (bus_wdata),
      .ctlb       (ctlb),
      .txb8       (txb8),
      .ctlc       (ctlc),
      .divisor    (cfg_divisor),
      .dbl        (cfg_dbl_speed),
      .mpcm       (cfg_mpcm),
      .tx_en_rise (tx_en_rise),
      .changed    (cfg_changed)
   );

   assign cfg_rx_en      = ctlb[CB_RXEN];
   assign cfg_tx_en      = ctlb[CB_TXEN];
   assign ie_rx          = ctlb[CB_RXIE];
   assign ie_tx          = ctlb[CB_TXIE];
   assign ie_de          = ctlb[CB_DEIE];
   assign cfg_bits       = decode_bits({ctlb[CB_SZ2], ctlc[2:1]});
   assign cfg_parity_en  = ctlc[5];
   assign cfg_parity_odd = ctlc[4];
   assign cfg_two_stop   = ctlc[3];

   sport_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_wr    (bus_wr && sel_data),
      .data_rd    (bus_rd && sel_data),
      .st_wr      (bus_wr && sel_status),
      .st_w1c_tx  (bus_wdata[ST_TXC]),
      .tx_en_rise (tx_en_rise),
      .rx_accept  (rx_done && cfg_rx_en),
      .rx_word    (rx_word),
      .rx_ferr    (rx_ferr),
      .rx_perr    (rx_perr),
      .tx_done    (tx_done),
      .flags      (flags),
      .ferr       (st_fe),
      .overrun    (st_dor),
      .perr       (st_upe),
      .rx_buf     (rx_buf)
   );

   assign st_rxc = flags.rx_done;
   assign st_tc  = flags.tx_done;
   assign st_dre = flags.data_empty;

   logic [N_IRQ-1:0] irq_vec;
   sport_irq #(.N(N_IRQ), .REG(1'b1)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag   ({st_rxc, st_tc, st_dre}),
      .enable ({ie_rx, ie_tx, ie_de}),
      .req    (irq_vec)
   );
   assign {irq_rx_done, irq_tx_done, irq_data_empty} = irq_vec;

   // transmit hand-off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_load <= 1'b0;
         tx_word <= '0;
      end else begin
         tx_load <= bus_wr && sel_data;
         if (bus_wr && sel_data) tx_word <= {txb8, bus_wdata};
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (sel_status)
         bus_rdata = {st_rxc, st_tc, st_dre, st_fe, st_dor, st_upe, cfg_dbl_speed, cfg_mpcm};
      else if (sel_ctlb)
         bus_rdata = {ctlb, rx_buf[WORD_W-1], txb8};
      else if (sel_ctlc)
         bus_rdata = ctlc;
      else if (sel_divl)
         bus_rdata = cfg_divisor[BYTE_W-1:0];
      else if (sel_divh)
         bus_rdata = BYTE_W'(cfg_divisor[DIV_W-1:BYTE_W]);
      else if (sel_data)
         bus_rdata = rx_buf[BYTE_W-1:0] & read_mask(cfg_bits);
   end
endmodule

// File: rtl/sport_regfile_chk.sv
module sport_regfile_chk #(
   parameter int ADDR_W   = 3,
   parameter int OFF_DATA = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              rx_done,
   input logic              cfg_rx_en,
   input logic              tx_load,
   input logic              cfg_changed,
   input logic              irq_rx_done,
   input logic              st_rxc,
   input logic              st_tc,
   input logic              st_dre,
   input logic              ie_rx
);
   logic at_data;
   assign at_data = (32'(bus_addr) == OFF_DATA);

   assert_wr_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_data) |=> (!st_tc && !st_dre));

   assert_load_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_data) |=> tx_load);

   assert_rx_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !cfg_rx_en && !st_rxc) |=> !st_rxc);

   assert_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_data && !rx_done) |=> !st_rxc);

   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rxc && ie_rx) |=> irq_rx_done);

   assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_changed |-> $past(bus_wr));

   assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_changed && !$past(bus_wr, 2)) |=> !cfg_changed || $past(bus_wr));
endmodule

bind sport_regfile sport_regfile_chk #(.ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .rx_done     (rx_done),
   .cfg_rx_en   (cfg_rx_en),
   .tx_load     (tx_load),
   .cfg_changed (cfg_changed),
   .irq_rx_done (irq_rx_done),
   .st_rxc      (st_rxc),
   .st_tc       (st_tc),
   .st_dre      (st_dre),
   .ie_rx       (ie_rx)
);

// File: tb/test_sport_regfile.sv
module test_sport_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam logic [2:0] A_ST = 3'd0, A_CB = 3'd1, A_CC = 3'd2,
                          A_DL = 3'd3, A_DH = 3'd4, A_DT = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rx_done = 1'b0;
   logic [8:0]  rx_word = '0;
   logic        rx_ferr = 1'b0, rx_perr = 1'b0;
   logic        tx_done = 1'b0;
   logic        tx_load;
   logic [8:0]  tx_word;
   logic [3:0]  cfg_bits;
   logic        cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_dbl_speed, cfg_mpcm;
   logic        cfg_rx_en, cfg_tx_en;
   logic [15:0] cfg_divisor;
   logic        cfg_changed, irq_rx_done, irq_data_empty, irq_tx_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sport_regfile i_sport_regfile (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_done(rx_done), .rx_word(rx_word),
      .rx_ferr(rx_ferr), .rx_perr(rx_perr), .tx_done(tx_done), .tx_load(tx_load),
      .tx_word(tx_word), .cfg_bits(cfg_bits), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_dbl_speed(cfg_dbl_speed), .cfg_mpcm(cfg_mpcm), .cfg_rx_en(cfg_rx_en),
      .cfg_tx_en(cfg_tx_en), .cfg_divisor(cfg_divisor), .cfg_changed(cfg_changed),
      .irq_rx_done(irq_rx_done), .irq_data_empty(irq_data_empty), .irq_tx_done(irq_tx_done)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_rx(input logic [8:0] w, input logic fe, input logic pe);
      @(negedge clk);
      rx_word = w; rx_ferr = fe; rx_perr = pe; rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; rx_ferr = 1'b0; rx_perr = 1'b0;
   endtask

   task automatic pulse_tx();
      @(negedge clk);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(A_ST, d); check("R1 status", 16'(d), 16'h20);
      bus_read(A_CB, d); check("R1 ctlB", 16'(d), 16'h00);
      bus_read(A_CC, d); check("R1 ctlC", 16'(d), 16'h06);
      check("R1 irqs", {13'd0, irq_rx_done, irq_tx_done, irq_data_empty}, 16'h0);
      check("R1 bits", 16'(cfg_bits), 16'd8);
   endtask

   task automatic t_status_write();
      logic [7:0] d;
      bus_write(A_ST, 8'hFF);
      check("R11 dbl change pulse", 16'(cfg_changed), 16'h1);
      bus_read(A_ST, d); check("R2 only low bits stored", 16'(d), 16'h23);
      check("R8 dbl/mpcm outputs", {14'd0, cfg_dbl_speed, cfg_mpcm}, 16'h3);
      bus_write(A_ST, 8'h01);
      bus_read(A_ST, d); check("R2 clear dbl", 16'(d), 16'h21);
      bus_write(A_ST, 8'h01);
      check("R11 no change no pulse", 16'(cfg_changed), 16'h0);
      bus_write(A_ST, 8'h00);
   endtask

   task automatic t_transmit();
      logic [7:0] d;
      bus_write(A_CB, 8'h09);
      check("R11 txen pulse", 16'(cfg_changed), 16'h1);
      check("R8 tx_en", 16'(cfg_tx_en), 16'h1);
      bus_write(A_DT, 8'h5A);
      check("R4 tx_load", 16'(tx_load), 16'h1);
      check("R4 tx_word", 16'(tx_word), 16'h15A);
      bus_read(A_ST, d); check("R4 flags cleared", 16'(d), 16'h00);
      check("R4 load one cycle", 16'(tx_load), 16'h0);
      bus_write(A_CB, 8'h08);
      check("R11 txb8 change no pulse", 16'(cfg_changed), 16'h0);
      bus_read(A_ST, d); check("R3 no set when already on", 16'(d), 16'h00);
      pulse_tx();
      bus_read(A_ST, d); check("R5 tx_done sets flags", 16'(d), 16'h60);
      bus_write(A_ST, 8'h40);
      bus_read(A_ST, d); check("R2 w1c tx-done", 16'(d), 16'h20);
      bus_write(A_DT, 8'h11);
      bus_write(A_CB, 8'h00);
      bus_write(A_CB, 8'h08);
      bus_read(A_ST, d); check("R3 enable rise sets empty", 16'(d), 16'h20);
   endtask

   task automatic t_irq();
      bus_write(A_CB, 8'h28);
      check("R9 empty irq lags", 16'(irq_data_empty), 16'h0);
      @(negedge clk);
      check("R9 empty irq", 16'(irq_data_empty), 16'h1);
      bus_write(A_CB, 8'h48);
      @(negedge clk);
      check("R9 empty irq gated", 16'(irq_data_empty), 16'h0);
      pulse_tx();
      check("R9 tx irq lags", 16'(irq_tx_done), 16'h0);
      @(negedge clk);
      check("R9 tx irq", 16'(irq_tx_done), 16'h1);
      bus_write(A_ST, 8'h40);
      @(negedge clk);
      check("R9 tx irq drops", 16'(irq_tx_done), 16'h0);
      bus_write(A_CB, 8'h08);
   endtask

   task automatic t_receive();
      logic [7:0] d;
      pulse_rx(9'h1A5, 1'b1, 1'b0);
      bus_read(A_ST, d); check("R6 ignored when disabled", 16'(d[7]), 16'h0);
      bus_write(A_CB, 8'h98);
      pulse_rx(9'h1A5, 1'b1, 1'b1);
      bus_read(A_ST, d); check("R6 flags", 16'(d & 8'h9C), 16'h94);
      check("R10 irq asserted", 16'(irq_rx_done), 16'h1);
      repeat (4) @(negedge clk);
      check("R10 irq still held", 16'(irq_rx_done), 16'h1);
      bus_read(A_CB, d); check("R7 bit 8 readable", 16'(d), 16'h9A);
      bus_read(A_DT, d); check("R7 data", 16'(d), 16'hA5);
      @(negedge clk);
      check("R7 irq drops after read", 16'(irq_rx_done), 16'h0);
      bus_read(A_ST, d); check("R7 rx-done cleared", 16'(d[7]), 16'h0);
      pulse_rx(9'h001, 1'b0, 1'b0);
      pulse_rx(9'h002, 1'b0, 1'b0);
      bus_read(A_ST, d); check("R6 overrun", 16'(d & 8'h9C), 16'h88);
      bus_read(A_DT, d); check("R6 newest kept", 16'(d), 16'h02);
   endtask

   task automatic t_size();
      logic [7:0] d;
      bus_write(A_CC, 8'h00);
      check("R11 ctlC pulse", 16'(cfg_changed), 16'h1);
      check("R8 5 bits", 16'(cfg_bits), 16'd5);
      pulse_rx(9'h0FF, 1'b0, 1'b0);
      bus_read(A_DT, d); check("R7 mask 5", 16'(d), 16'h1F);
      bus_write(A_CC, 8'h02); check("R8 6 bits", 16'(cfg_bits), 16'd6);
      bus_write(A_CC, 8'h04); check("R8 7 bits", 16'(cfg_bits), 16'd7);
      pulse_rx(9'h0FF, 1'b0, 1'b0);
      bus_read(A_DT, d); check("R7 mask 7", 16'(d), 16'h7F);
      bus_write(A_CB, 8'h9C);
      check("R11 size2 pulse", 16'(cfg_changed), 16'h1);
      check("R8 code 6 gives 9", 16'(cfg_bits), 16'd9);
      bus_write(A_CC, 8'h00); check("R8 code 4 gives 9", 16'(cfg_bits), 16'd9);
      bus_write(A_CB, 8'h98);
      bus_write(A_CC, 8'h38);
      check("R8 parity/stop", {13'd0, cfg_parity_en, cfg_parity_odd, cfg_two_stop}, 16'h7);
      bus_write(A_CC, 8'h06);
      check("R8 back to 8", 16'(cfg_bits), 16'd8);
   endtask

   task automatic t_divisor();
      logic [7:0] d;
      bus_write(A_DL, 8'h34);
      check("R11 divl pulse", 16'(cfg_changed), 16'h1);
      @(negedge clk);
      check("R11 pulse one cycle", 16'(cfg_changed), 16'h0);
      bus_write(A_DH, 8'h12);
      check("R11 divh pulse", 16'(cfg_changed), 16'h1);
      check("R12 divisor", cfg_divisor, 16'h1234);
      bus_read(A_DH, d); check("R12 high readback", 16'(d), 16'h12);
      bus_write(A_CB, 8'hD8);
      check("R11 enable-only write no pulse", 16'(cfg_changed), 16'h0);
   endtask

   initial begin : watchdog
      for (int i = 0; i < WATCHDOG; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_status_write();
      t_transmit();
      t_irq();
      t_receive();
      t_size();
      t_divisor();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule